// File: doc/BRIEF.md
# Burst-of-Four DDR SRAM Controller

This block sits between a simple request/response interface on the host side and the memory port of a synchronous SRAM. That SRAM moves four data words per access on a double-data-rate bus. Each request carries a direction, an address, and, for a write, four words with active-low byte enables per word. The block accepts requests with a valid/ready handshake. It turns each accepted request into a single-cycle load command on the memory port. For a write, it places the four words on the two clock phases that follow the command. For a read, it gathers the four returned words into one response.

The block runs on the memory's K clock. Each of its data-bus ports carries two lanes per clock cycle: a rise lane for the word tied to the K rising edge and a fall lane for the word tied to the K# rising edge. A downstream PHY serialises these lanes and aligns the clocks; that PHY is not part of this block. The block also enforces the command-spacing and turnaround rules itself, by holding ready low for as long as the next request may not go out.

Top module: `ddrb4_sram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, memLdN is 1, memDqOe is 0, respValid is 0 and reqReady is 1 for both reads and writes.
- R2: A request accepted at a clock edge appears on the memory port for exactly the following cycle, with memLdN low, memRw 1 for a read or 0 for a write, and memAddr equal to the request address. In idle cycles memLdN is 1 and memRw is 1.
- R3: reqReady is 0 in every cycle in which a command is on the port, so commands are at least two cycles apart. Requests presented back to back issue exactly two cycles apart when no turnaround applies.
- R4: In the first cycle after a write command, memDqRise carries word 0 and memDqFall carries word 1. In the second cycle they carry words 2 and 3. Word k of reqWdata sits at bits k*DATA_W. memDqOe is 1 in exactly those two cycles, and the data lanes are 0 otherwise.
- R5: Byte enables are active low. memBwRiseN and memBwFallN follow their words in the same cycles and lanes, with word k of reqBwN at bits k*BE_W. When the bus is released both are all ones.
- R6: A write command goes on the port no sooner than 2*(TURN_SLOTS+1) cycles after the most recent read command. With TURN_SLOTS=2, the slot that would turn into a no-op and one extra idle slot stay empty. A read after a write, or a read after a read, needs no extra gap.
- R7: Word k of a read burst is the value on the memory's returned data at half-cycle RD_LAT_HALF+k after the command cycle starts. Half-cycle 2c is the rise lane c cycles after the command, and half-cycle 2c+1 is the fall lane of that cycle.
- R8: respValid is a one-cycle pulse in cycle (RD_LAT_HALF+3)/2+1 after the read command. It comes with all four words in respData, word k at bits k*DATA_W. There is exactly one pulse per read.
- R9: With an odd RD_LAT_HALF, two reads two cycles apart share one capture cycle: the last word of the first read arrives on the rise lane and the first word of the second read on the fall lane. Both responses are still returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | K clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request may be taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Burst address |
| reqWdata | input | 4*DATA_W | Four write words, word 0 lowest |
| reqBwN | input | 4*BE_W | Active-low byte enables, per word |
| respValid | output | 1 | Read response pulse |
| respData | output | 4*DATA_W | Four read words, word 0 lowest |
| memLdN | output | 1 | Active-low load command |
| memRw | output | 1 | 1 = read, 0 = write |
| memAddr | output | ADDR_W | Address to memory |
| memDqOe | output | 1 | Data bus drive enable |
| memDqRise | output | DATA_W | Write word for K rise |
| memDqFall | output | DATA_W | Write word for K# rise |
| memBwRiseN | output | BE_W | Byte enables for K rise word |
| memBwFallN | output | BE_W | Byte enables for K# rise word |
| memDqInRise | input | DATA_W | Read word sampled at K rise |
| memDqInFall | input | DATA_W | Read word sampled at K# rise |

## Verification
The bench builds the block with RD_LAT_HALF=5 and TURN_SLOTS=2, at 18-bit words with two byte enables. The odd latency makes a read burst start on a fall lane and end on a rise lane, so back-to-back reads overlap in one capture cycle and the R9 case is exercised. A turnaround of two slots makes a write queued right behind a read wait exactly six cycles. Pairs of writes and a write followed by a read must still issue two cycles apart. A bench-side memory returns a distinct value on every half-cycle, so any shift in the capture point or in the word order shows up as a wrong word.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;

  // Per-cycle strobes from the command sequencer to the datapath.
  typedef struct packed {
    logic takeReq;     // request accepted at this edge
    logic sendFirst;   // write command on port: load words 0/1 at this edge
    logic sendSecond;  // load words 2/3 at this edge
    logic readOnBus;   // read command on port this cycle
  } ddrb4Strobe_t;

endpackage

// File: rtl/ddrb4_ctrl.sv
module ddrb4_ctrl
  import ddrb4_pkg::*;
#(
  parameter int TURN_SLOTS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output ddrb4Strobe_t strobe,
  output logic         memLdN,
  output logic         memRw
);

  // Cycles that must pass after a read command before a write may be accepted.
  localparam int WR_GAP = 2 * (TURN_SLOTS + 1) - 1;
  localparam int AGE_W  = $clog2(WR_GAP + 1) + 1;
  localparam logic [AGE_W-1:0] GAP_L   = AGE_W'(WR_GAP);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] rdAge;
  logic             secondPend;
  logic             accept;
  logic             cmdOnPort;

  assign cmdOnPort = !memLdN;
  assign reqReady  = !cmdOnPort && !(reqWrite && (rdAge < GAP_L));
  assign accept    = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memLdN     <= 1'b1;
      memRw      <= 1'b1;
      rdAge      <= AGE_MAX;
      secondPend <= 1'b0;
    end else begin
      memLdN     <= !accept;
      memRw      <= accept ? !reqWrite : 1'b1;
      secondPend <= cmdOnPort && !memRw;
      if (accept && !reqWrite) begin
        rdAge <= '0;
      end else if (rdAge != AGE_MAX) begin
        rdAge <= rdAge + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.takeReq    = accept;
    strobe.sendFirst  = cmdOnPort && !memRw;
    strobe.sendSecond = secondPend;
    strobe.readOnBus  = cmdOnPort && memRw;
  end

  // R3: a command is never followed by another in the next cycle
  p_cmd_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memLdN |=> memLdN);

  // R6: a write on the port has the turnaround window behind it
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!memLdN && !memRw) |-> (rdAge > GAP_L));

  // R2: idle cycles keep the direction line at read
  p_idle_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    memLdN |-> memRw);

endmodule

// File: rtl/ddrb4_data.sv
module ddrb4_data
  import ddrb4_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int BE_W        = 2,
  parameter int ADDR_W      = 18,
  parameter int RD_LAT_HALF = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ddrb4Strobe_t          strobe,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [4*DATA_W-1:0]   reqWdata,
  input  logic [4*BE_W-1:0]     reqBwN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memDqOe,
  output logic [DATA_W-1:0]     memDqRise,
  output logic [DATA_W-1:0]     memDqFall,
  output logic [BE_W-1:0]       memBwRiseN,
  output logic [BE_W-1:0]       memBwFallN,
  input  logic [DATA_W-1:0]     memDqInRise,
  input  logic [DATA_W-1:0]     memDqInFall,
  output logic                  respValid,
  output logic [4*DATA_W-1:0]   respData
);

  localparam int LAST_C = (RD_LAT_HALF + 3) / 2;
  localparam int DEPTH  = LAST_C + 1;

  // ---------------- write side ----------------
  logic [4*DATA_W-1:0] holdData;
  logic [4*BE_W-1:0]   holdBwN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      holdData <= '0;
      holdBwN  <= '1;
    end else if (strobe.takeReq) begin
      memAddr  <= reqAddr;
      holdData <= reqWdata;
      holdBwN  <= reqBwN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memDqOe    <= 1'b0;
      memDqRise  <= '0;
      memDqFall  <= '0;
      memBwRiseN <= '1;
      memBwFallN <= '1;
    end else if (strobe.sendFirst) begin
      memDqOe    <= 1'b1;
      memDqRise  <= holdData[0*DATA_W +: DATA_W];
      memDqFall  <= holdData[1*DATA_W +: DATA_W];
      memBwRiseN <= holdBwN[0*BE_W +: BE_W];
      memBwFallN <= holdBwN[1*BE_W +: BE_W];
    end else if (strobe.sendSecond) begin
      memDqOe    <= 1'b1;
      memDqRise  <= holdData[2*DATA_W +: DATA_W];
      memDqFall  <= holdData[3*DATA_W +: DATA_W];
      memBwRiseN <= holdBwN[2*BE_W +: BE_W];
      memBwFallN <= holdBwN[3*BE_W +: BE_W];
    end else begin
      memDqOe    <= 1'b0;
      memDqRise  <= '0;
      memDqFall  <= '0;
      memBwRiseN <= '1;
      memBwFallN <= '1;
    end
  end

  // ---------------- read side ----------------
  // rdFlag[c] is set when a read command was on the port c cycles ago.
  logic [DEPTH-1:1]    flagPipe;
  logic [DEPTH-1:0]    rdFlag;
  logic [DATA_W-1:0]   bufReg  [4];
  logic [DATA_W-1:0]   bufNext [4];
  logic [DATA_W-1:0]   finWord [4];
  logic [4*DATA_W-1:0] finPacked;
  logic [1:0]          slot;

  assign rdFlag = {flagPipe, strobe.readOnBus};

  always_comb begin
    slot = '0;
    for (int k = 0; k < 4; k++) begin
      bufNext[k] = bufReg[k];
      finWord[k] = bufReg[k];
    end
    for (int c = 0; c < DEPTH; c++) begin
      for (int l = 0; l < 2; l++) begin
        if (rdFlag[c] && (2*c + l >= RD_LAT_HALF) && (2*c + l <= RD_LAT_HALF + 3)) begin
          slot = 2'(2*c + l - RD_LAT_HALF);
          bufNext[slot] = (l == 0) ? memDqInRise : memDqInFall;
          // words finishing a burst must not be confused with the next burst
          if (c == LAST_C) begin
            finWord[slot] = (l == 0) ? memDqInRise : memDqInFall;
          end
        end
      end
    end
    for (int k = 0; k < 4; k++) begin
      finPacked[k*DATA_W +: DATA_W] = finWord[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagPipe  <= '0;
      respValid <= 1'b0;
      respData  <= '0;
      for (int k = 0; k < 4; k++) bufReg[k] <= '0;
    end else begin
      flagPipe  <= rdFlag[DEPTH-2:0];
      respValid <= rdFlag[LAST_C];
      if (rdFlag[LAST_C]) respData <= finPacked;
      for (int k = 0; k < 4; k++) bufReg[k] <= bufNext[k];
    end
  end

  // R4: a write command drives the bus for two consecutive cycles
  p_write_two_cycles_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sendFirst |=> memDqOe ##1 memDqOe);

  // R5: released bus carries no write enables
  p_bw_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memDqOe |-> ((&memBwRiseN) && (&memBwFallN)));

  // R8: response valid is a single-cycle pulse
  p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

endmodule

// File: rtl/ddrb4_sram_ctrl.sv
module ddrb4_sram_ctrl
  import ddrb4_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int BE_W        = 2,
  parameter int ADDR_W      = 18,
  parameter int RD_LAT_HALF = 5,
  parameter int TURN_SLOTS  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [4*DATA_W-1:0] reqWdata,
  input  logic [4*BE_W-1:0]   reqBwN,
  output logic                respValid,
  output logic [4*DATA_W-1:0] respData,
  output logic                memLdN,
  output logic                memRw,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memDqOe,
  output logic [DATA_W-1:0]   memDqRise,
  output logic [DATA_W-1:0]   memDqFall,
  output logic [BE_W-1:0]     memBwRiseN,
  output logic [BE_W-1:0]     memBwFallN,
  input  logic [DATA_W-1:0]   memDqInRise,
  input  logic [DATA_W-1:0]   memDqInFall
);

  ddrb4Strobe_t strobe;

  ddrb4_ctrl #(
    .TURN_SLOTS(TURN_SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strobe   (strobe),
    .memLdN   (memLdN),
    .memRw    (memRw)
  );

  ddrb4_data #(
    .DATA_W      (DATA_W),
    .BE_W        (BE_W),
    .ADDR_W      (ADDR_W),
    .RD_LAT_HALF (RD_LAT_HALF)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .reqBwN      (reqBwN),
    .memAddr     (memAddr),
    .memDqOe     (memDqOe),
    .memDqRise   (memDqRise),
    .memDqFall   (memDqFall),
    .memBwRiseN  (memBwRiseN),
    .memBwFallN  (memBwFallN),
    .memDqInRise (memDqInRise),
    .memDqInFall (memDqInFall),
    .respValid   (respValid),
    .respData    (respData)
  );

endmodule

// File: tb/ddrb4_sram_ctrl_test.sv
module ddrb4_sram_ctrl_test;

  localparam int DATA_W = 18;
  localparam int BE_W   = 2;
  localparam int ADDR_W = 18;
  localparam int LAT    = 5;
  localparam int TURN   = 2;
  localparam int RESP_AT = (LAT + 3) / 2 + 1;
  localparam int WR_MIN  = 2 * (TURN + 1);

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                reqValid = 1'b0;
  logic                reqReady;
  logic                reqWrite = 1'b0;
  logic [ADDR_W-1:0]   reqAddr = '0;
  logic [4*DATA_W-1:0] reqWdata = '0;
  logic [4*BE_W-1:0]   reqBwN = '1;
  logic                respValid;
  logic [4*DATA_W-1:0] respData;
  logic                memLdN, memRw, memDqOe;
  logic [ADDR_W-1:0]   memAddr;
  logic [DATA_W-1:0]   memDqRise, memDqFall;
  logic [BE_W-1:0]     memBwRiseN, memBwFallN;
  logic [DATA_W-1:0]   memDqInRise = '0;
  logic [DATA_W-1:0]   memDqInFall = '0;

  ddrb4_sram_ctrl #(
    .DATA_W(DATA_W), .BE_W(BE_W), .ADDR_W(ADDR_W),
    .RD_LAT_HALF(LAT), .TURN_SLOTS(TURN)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBwN(reqBwN),
    .respValid(respValid), .respData(respData),
    .memLdN(memLdN), .memRw(memRw), .memAddr(memAddr), .memDqOe(memDqOe),
    .memDqRise(memDqRise), .memDqFall(memDqFall),
    .memBwRiseN(memBwRiseN), .memBwFallN(memBwFallN),
    .memDqInRise(memDqInRise), .memDqInFall(memDqInFall)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // value the bench memory places on half-cycle h
  function automatic logic [DATA_W-1:0] pat(input int h);
    return DATA_W'(h * 37 + 11);
  endfunction

  // bench memory: distinct value on each half-cycle
  always @(negedge clk) begin
    memDqInRise <= pat(2 * cyc);
    memDqInFall <= pat(2 * cyc + 1);
  end

  // expectation queues and port monitor
  logic [ADDR_W:0]     expCmdQ[$];
  logic [4*DATA_W-1:0] expWdQ[$];
  logic [4*BE_W-1:0]   expBwQ[$];
  int                  rdCycQ[$];
  int                  lastCmd = -100;
  int                  lastRead = -100;
  bit                  s1Valid = 0, s2Valid = 0;
  logic [4*DATA_W-1:0] s1Data, s2Data;
  logic [4*BE_W-1:0]   s1Bw, s2Bw;

  always @(negedge clk) begin
    if (rstN) begin
      // R4, R5: write data lanes and byte enables
      if (s1Valid) begin
        chk(memDqOe == 1'b1, "R4 oe first", 64'(memDqOe), 64'(1));
        chk(memDqRise == s1Data[0 +: DATA_W], "R4 word0", 64'(memDqRise), 64'(s1Data[0 +: DATA_W]));
        chk(memDqFall == s1Data[DATA_W +: DATA_W], "R4 word1", 64'(memDqFall), 64'(s1Data[DATA_W +: DATA_W]));
        chk(memBwRiseN == s1Bw[0 +: BE_W], "R5 bw0", 64'(memBwRiseN), 64'(s1Bw[0 +: BE_W]));
        chk(memBwFallN == s1Bw[BE_W +: BE_W], "R5 bw1", 64'(memBwFallN), 64'(s1Bw[BE_W +: BE_W]));
      end else if (s2Valid) begin
        chk(memDqOe == 1'b1, "R4 oe second", 64'(memDqOe), 64'(1));
        chk(memDqRise == s2Data[2*DATA_W +: DATA_W], "R4 word2", 64'(memDqRise), 64'(s2Data[2*DATA_W +: DATA_W]));
        chk(memDqFall == s2Data[3*DATA_W +: DATA_W], "R4 word3", 64'(memDqFall), 64'(s2Data[3*DATA_W +: DATA_W]));
        chk(memBwRiseN == s2Bw[2*BE_W +: BE_W], "R5 bw2", 64'(memBwRiseN), 64'(s2Bw[2*BE_W +: BE_W]));
        chk(memBwFallN == s2Bw[3*BE_W +: BE_W], "R5 bw3", 64'(memBwFallN), 64'(s2Bw[3*BE_W +: BE_W]));
      end else begin
        chk(memDqOe == 1'b0 && memDqRise == '0 && memDqFall == '0, "R4 released",
            64'({memDqOe, memDqRise}), 64'(0));
        chk((&memBwRiseN) && (&memBwFallN), "R5 idle enables", 64'({memBwRiseN, memBwFallN}), 64'hF);
      end
      s2Valid = s1Valid; s2Data = s1Data; s2Bw = s1Bw;
      s1Valid = 0;
      if (!memLdN) begin
        if (expCmdQ.size() == 0) begin
          chk(1'b0, "R2 unexpected command", 64'(memAddr), 64'(0));
        end else begin
          logic [ADDR_W:0] e;
          e = expCmdQ.pop_front();
          chk(memRw == !e[ADDR_W], "R2 direction", 64'(memRw), 64'(!e[ADDR_W]));
          chk(memAddr == e[ADDR_W-1:0], "R2 address", 64'(memAddr), 64'(e[ADDR_W-1:0]));
          chk(!reqReady, "R3 ready low during command", 64'(reqReady), 64'(0));
          chk(cyc - lastCmd >= 2, "R3 spacing", 64'(cyc - lastCmd), 64'(2));
          if (e[ADDR_W]) begin
            chk(cyc - lastRead >= WR_MIN, "R6 turnaround", 64'(cyc - lastRead), 64'(WR_MIN));
            s1Valid = 1;
            s1Data = expWdQ.pop_front();
            s1Bw = expBwQ.pop_front();
          end else begin
            lastRead = cyc;
            rdCycQ.push_back(cyc);
          end
        end
        lastCmd = cyc;
      end
      if (respValid) begin
        if (rdCycQ.size() == 0) begin
          chk(1'b0, "R8 unexpected response", 64'(cyc), 64'(0));
        end else begin
          int n;
          n = rdCycQ.pop_front();
          chk(cyc == n + RESP_AT, "R8 response cycle", 64'(cyc - n), 64'(RESP_AT));
          for (int k = 0; k < 4; k++) begin
            chk(respData[k*DATA_W +: DATA_W] == pat(2*n + LAT + k), "R7 R9 read word",
                64'(respData[k*DATA_W +: DATA_W]), 64'(pat(2*n + LAT + k)));
          end
        end
      end
    end
  end

  task automatic send(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [4*DATA_W-1:0] d, input logic [4*BE_W-1:0] b,
                      output int portCyc);
    @(negedge clk); #1;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBwN = b;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    expCmdQ.push_back({wr, a});
    if (wr) begin
      expWdQ.push_back(d);
      expBwQ.push_back(b);
    end
    portCyc = cyc + 1;
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  function automatic logic [4*DATA_W-1:0] mkData(input int i);
    logic [4*DATA_W-1:0] r;
    for (int k = 0; k < 4; k++) r[k*DATA_W +: DATA_W] = DATA_W'(i * 4096 + k * 257 + 5);
    return r;
  endfunction

  function automatic logic [4*BE_W-1:0] mkBw(input int i);
    logic [4*BE_W-1:0] r;
    for (int k = 0; k < 4; k++) r[k*BE_W +: BE_W] = BE_W'(i + k);
    return r;
  endfunction

  // {write, idle gap, address}
  localparam int NVEC = 10;
  localparam logic [ADDR_W+3:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 18'h00010},  // write
    {1'b1, 3'd0, 18'h00020},  // back-to-back write (R3)
    {1'b0, 3'd0, 18'h00010},  // read after write
    {1'b1, 3'd0, 18'h00030},  // write stalled behind read (R6)
    {1'b0, 3'd0, 18'h00040},  // read
    {1'b0, 3'd0, 18'h00050},  // back-to-back read, shared capture cycle (R9)
    {1'b0, 3'd3, 18'h3FFFF},  // read, top address
    {1'b1, 3'd5, 18'h2AAAA},  // write after long idle
    {1'b1, 3'd0, 18'h15555},  // write
    {1'b0, 3'd2, 18'h00001}   // read
  };

  initial begin
    int t1, t2, t3, t4, t5;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(memLdN == 1'b1, "R1 LD idle in reset", 64'(memLdN), 64'(1));
    chk(memDqOe == 1'b0, "R1 bus released in reset", 64'(memDqOe), 64'(0));
    chk(respValid == 1'b0, "R1 no response in reset", 64'(respValid), 64'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    reqWrite = 1'b1;
    #1;
    chk(reqReady == 1'b1, "R1 ready for write after reset", 64'(reqReady), 64'(1));
    reqWrite = 1'b0;
    #1;
    chk(reqReady == 1'b1 && memLdN == 1'b1, "R1 ready for read after reset",
        64'({reqReady, memLdN}), 64'(3));

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      repeat (int'(VEC[i][ADDR_W+2:ADDR_W])) @(negedge clk);
      send(VEC[i][ADDR_W+3], VEC[i][ADDR_W-1:0], mkData(i), mkBw(i), t1);
    end
    repeat (12) @(negedge clk);

    // directed: R6 write queued right behind a read
    send(1'b0, 18'h00100, '0, '1, t1);
    send(1'b1, 18'h00104, mkData(20), mkBw(20), t2);
    chk(t2 - t1 == WR_MIN, "R6 read-to-write gap", 64'(t2 - t1), 64'(WR_MIN));
    repeat (10) @(negedge clk);

    // directed: R3 spacing, R6 no gap for write-to-read, R9 read pair
    send(1'b1, 18'h00200, mkData(21), mkBw(21), t1);
    send(1'b1, 18'h00204, mkData(22), mkBw(22), t2);
    chk(t2 - t1 == 2, "R3 write pair two cycles apart", 64'(t2 - t1), 64'(2));
    send(1'b0, 18'h00200, '0, '1, t3);
    chk(t3 - t2 == 2, "R6 write-to-read needs no gap", 64'(t3 - t2), 64'(2));
    send(1'b0, 18'h00204, '0, '1, t4);
    chk(t4 - t3 == 2, "R9 read pair two cycles apart", 64'(t4 - t3), 64'(2));
    send(1'b1, 18'h00208, mkData(23), mkBw(23), t5);
    chk(t5 - t4 == WR_MIN, "R6 gap from latest read", 64'(t5 - t4), 64'(WR_MIN));

    repeat (20) @(negedge clk);
    chk(rdCycQ.size() == 0, "R8 every read answered", 64'(rdCycQ.size()), 64'(0));
    chk(expCmdQ.size() == 0, "R2 every request issued", 64'(expCmdQ.size()), 64'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule